// File: doc/BRIEF.md
# Memory-Mapped Cache Tag Array Port

This block is a bus slave that lets software read and rewrite the tag store of a two-way set-associative data cache as if it were ordinary memory. Each request carries a 32-bit address and a 32-bit data word. The address chooses a way and an entry. The data word carries the tag, the dirty flag (U) and the valid flag (V). The block holds the tag store itself: two ways, each with 512 entries of a 19-bit tag plus the U and V flags.

There are three kinds of access. A read returns the tag and flags of one way and entry. A direct write stores a tag and flags into a named way and entry. A matching write compares a tag against both ways of an entry and rewrites only the flags of the way that hits. A RAM-mode input moves the way-select bit to a lower address bit.

The control sequencer has three states. `ST_IDLE` means nothing is pending. `ST_RD_RESP` presents read data for one cycle. `ST_AS_UPD` performs the tag compare and the flag update of a matching write. Every cycle the sequencer looks at the incoming request and moves to one of these states, whatever state it is in now:
- a selected read goes to `ST_RD_RESP`;
- a selected write with the match flag set goes to `ST_AS_UPD`;
- anything else goes to `ST_IDLE`, including a direct write, which completes on its request edge.

Top module: `ctag_port`

## Requirements
- R1: An access is taken only when `addr[31:24]` is 0xF4 and `addr[1:0]` is 0. Any other request produces no `rvalid`, no `hit_pulse` and no change to the store.
- R2: With `ram_mode`=0, the way is `addr[14]` and the entry index is `addr[13:5]`.
- R3: With `ram_mode`=1, the way is `addr[13]` and the entry index is {`addr[14]`, `addr[12:5]`}.
- R4: In the data word, the tag is bits [28:10], U is bit 1 and V is bit 0. Bits [31:29] and [9:2] are ignored on writes.
- R5: A selected read asserts `rvalid` for exactly one cycle, in the cycle after the request. In that cycle `rdata[28:10]` is the stored tag, `rdata[1]` is U, `rdata[0]` is V, and every other bit is 0. Address bit 3 has no effect on a read.
- R6: A selected write with `addr[3]`=0 stores the tag, U and V into the addressed way and entry, with no compare.
- R7: A selected write with `addr[3]`=1 compares data bits [28:10] with the tag of each valid way at the addressed entry.
  - On a hit, only U and V of the matching way are rewritten, and its tag is kept.
  - If both ways match, way 0 is chosen.
  - If neither way matches, nothing is written.
- R8: `hit_pulse` is high for one cycle, in the cycle after a matching write that hits, and `hit_way` then gives the way. A miss, a read or a direct write gives no pulse.
- R9: After reset, every V and U bit of both ways reads 0.
- R10: `rdata` is all zero whenever `rvalid` is low.
- R11: A new request may arrive in every cycle, and requests take effect in order. When a matching write is followed directly by a direct write to the same way and entry, the direct write's values remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request valid for one cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Access address |
| wdata | input | 32 | Write data word |
| ram_mode | input | 1 | Moves the way-select bit from 14 to 13 |
| rvalid | output | 1 | Read data valid |
| rdata | output | 32 | Read data word |
| hit_pulse | output | 1 | A matching write hit a way |
| hit_way | output | 1 | Way that hit |

## Verification
The hardest case to reach is a flag update from a matching write landing on the same edge as a direct write to that entry. Reaching it needs two selected writes on consecutive cycles with no idle cycle between them.

The stimulus first fills both ways of an entry with known tags. It then drives the matching write and the direct write back to back, and reads the entry to see which values remain.

Matches against an invalid way and double matches also need the store to be prepared first. The bench sets them up with direct writes before issuing the compare.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_RESP,
        ST_AS_UPD
    } ctag_state_e;

    localparam logic [7:0] CTAG_WINDOW = 8'hF4;
    localparam int CTAG_TAG_LSB   = 10;
    localparam int CTAG_IDX_LSB   = 5;
    localparam int CTAG_MATCH_BIT = 3;
endpackage

// File: rtl/ctag_decode.sv
module ctag_decode
    import ctag_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int TAG_W = 19
) (
    input  logic [31:0]      addr,
    input  logic [31:0]      wdata,
    input  logic             ram_mode,
    output logic             sel,
    output logic             way,
    output logic [IDX_W-1:0] idx,
    output logic             match_wr,
    output logic [TAG_W-1:0] tag,
    output logic             u_bit,
    output logic             v_bit
);
    localparam int WAY_HI = CTAG_IDX_LSB + IDX_W;
    localparam int WAY_LO = WAY_HI - 1;

    logic unused_bits;

    assign sel      = (addr[31:24] == CTAG_WINDOW) && (addr[1:0] == 2'b00);
    assign match_wr = addr[CTAG_MATCH_BIT];
    assign tag      = wdata[CTAG_TAG_LSB +: TAG_W];
    assign u_bit    = wdata[1];
    assign v_bit    = wdata[0];

    always_comb begin
        if (ram_mode) begin
            way = addr[WAY_LO];
            idx = {addr[WAY_HI], addr[CTAG_IDX_LSB +: IDX_W-1]};
        end else begin
            way = addr[WAY_HI];
            idx = addr[CTAG_IDX_LSB +: IDX_W];
        end
    end

    assign unused_bits = ^{addr[23:WAY_HI+1], addr[4], addr[2], wdata[31:CTAG_TAG_LSB+TAG_W], wdata[9:2]};
endmodule

// File: rtl/ctag_way.sv
module ctag_way #(
    parameter int ENTRIES = 512,
    parameter int TAG_W   = 19,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_u,
    output logic             rd_v,
    input  logic             fl_en,
    input  logic [IDX_W-1:0] fl_idx,
    input  logic             fl_u,
    input  logic             fl_v,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_u,
    input  logic             wr_v
);
    logic [TAG_W-1:0]   tag_mem [ENTRIES];
    logic [ENTRIES-1:0] u_q;
    logic [ENTRIES-1:0] v_q;

    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_idx] <= wr_tag;
    end

    // The flag-only port is older; the full write port is applied last and wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_q <= '0;
            v_q <= '0;
        end else begin
            if (fl_en) begin
                u_q[fl_idx] <= fl_u;
                v_q[fl_idx] <= fl_v;
            end
            if (wr_en) begin
                u_q[wr_idx] <= wr_u;
                v_q[wr_idx] <= wr_v;
            end
        end
    end

    assign rd_tag = tag_mem[rd_idx];
    assign rd_u   = u_q[rd_idx];
    assign rd_v   = v_q[rd_idx];
endmodule

// File: rtl/ctag_port.sv
module ctag_port
    import ctag_pkg::*;
#(
    parameter int ENTRIES = 512,
    parameter int TAG_W   = 19
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        wr,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    input  logic        ram_mode,
    output logic        rvalid,
    output logic [31:0] rdata,
    output logic        hit_pulse,
    output logic        hit_way
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int WAYS  = 2;

    ctag_state_e state_q, state_d;

    logic             d_sel, d_way, d_match, d_u, d_v;
    logic [IDX_W-1:0] d_idx;
    logic [TAG_W-1:0] d_tag;

    logic             cap_way, cap_u, cap_v;
    logic [IDX_W-1:0] cap_idx;
    logic [TAG_W-1:0] cap_tag;

    logic [TAG_W-1:0] rd_tag [WAYS];
    logic             rd_u   [WAYS];
    logic             rd_v   [WAYS];
    logic [WAYS-1:0]  fl_en;
    logic [WAYS-1:0]  wr_en;
    logic [WAYS-1:0]  way_hit;

    ctag_decode #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dec (
        .addr     (addr),
        .wdata    (wdata),
        .ram_mode (ram_mode),
        .sel      (d_sel),
        .way      (d_way),
        .idx      (d_idx),
        .match_wr (d_match),
        .tag      (d_tag),
        .u_bit    (d_u),
        .v_bit    (d_v)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign wr_en[w]   = req && wr && d_sel && !d_match && (d_way == w[0]);
        assign way_hit[w] = rd_v[w] && (rd_tag[w] == cap_tag);

        ctag_way #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_way (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_idx (cap_idx),
            .rd_tag (rd_tag[w]),
            .rd_u   (rd_u[w]),
            .rd_v   (rd_v[w]),
            .fl_en  (fl_en[w]),
            .fl_idx (cap_idx),
            .fl_u   (cap_u),
            .fl_v   (cap_v),
            .wr_en  (wr_en[w]),
            .wr_idx (d_idx),
            .wr_tag (d_tag),
            .wr_u   (d_u),
            .wr_v   (d_v)
        );
    end

    // Next state from the incoming request, whatever the present state.
    always_comb begin
        state_d = ST_IDLE;
        if (req && d_sel) begin
            if (!wr)         state_d = ST_RD_RESP;
            else if (d_match) state_d = ST_AS_UPD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (req && d_sel) begin
            cap_way <= d_way;
            cap_idx <= d_idx;
            cap_tag <= d_tag;
            cap_u   <= d_u;
            cap_v   <= d_v;
        end
    end

    always_comb begin
        rvalid    = 1'b0;
        rdata     = '0;
        hit_pulse = 1'b0;
        hit_way   = 1'b0;
        fl_en     = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_RESP: begin
                rvalid                     = 1'b1;
                rdata[CTAG_TAG_LSB +: TAG_W] = rd_tag[cap_way];
                rdata[1]                   = rd_u[cap_way];
                rdata[0]                   = rd_v[cap_way];
            end
            ST_AS_UPD: begin
                if (way_hit[0]) begin
                    hit_pulse = 1'b1;
                    fl_en[0]  = 1'b1;
                end else if (way_hit[1]) begin
                    hit_pulse = 1'b1;
                    hit_way   = 1'b1;
                    fl_en[1]  = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ctag_chk.sv
module ctag_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        wr,
    input logic [31:0] addr,
    input logic        rvalid,
    input logic [31:0] rdata,
    input logic        hit_pulse
);
    logic sel;
    assign sel = (addr[31:24] == 8'hF4) && (addr[1:0] == 2'b00);

    a_r1_unselected_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !sel) |=> (!rvalid && !hit_pulse));

    a_r5_read_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req && sel && !wr) |=> rvalid);

    a_r5_no_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr) |=> !rvalid);

    a_r4_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rdata[31:29] == 3'b000 && rdata[9:2] == 8'h00));

    a_r8_hit_only_after_match_write: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |-> $past(req && wr && addr[3] && sel));

    a_r8_no_hit_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (req && sel && !(wr && addr[3])) |=> !hit_pulse);

    a_r10_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == 32'h0));
endmodule

bind ctag_port ctag_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .wr        (wr),
    .addr      (addr),
    .rvalid    (rvalid),
    .rdata     (rdata),
    .hit_pulse (hit_pulse)
);

// File: tb/sim_ctag_port.sv
module sim_ctag_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ram_mode = 1'b0;
    logic        rvalid, hit_pulse, hit_way;
    logic [31:0] rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ctag_port u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .ram_mode(ram_mode), .rvalid(rvalid), .rdata(rdata),
        .hit_pulse(hit_pulse), .hit_way(hit_way)
    );

    typedef struct {
        bit          is_hit;
        logic [31:0] data;
        logic [31:0] mask;
        bit          way;
        string       rq;
    } exp_t;

    exp_t exp_q[$];

    // Reference model of the store
    logic [18:0] m_tag   [2][512];
    bit          m_v     [2][512];
    bit          m_u     [2][512];
    bit          m_known [2][512];

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
        end
    endtask

    function automatic logic [31:0] mk_addr(bit match, bit b14, bit b13, logic [7:0] low_idx);
        return {8'hF4, 9'd0, b14, b13, low_idx, 1'b0, match, 3'b000};
    endfunction

    // Drives one request cycle and updates the model (R1..R8, R11 order).
    task automatic issue(bit w, logic [31:0] a, logic [31:0] d, string rq);
        bit sel, way;
        int idx;
        logic [18:0] t;
        exp_t e;
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        sel = (a[31:24] == 8'hF4) && (a[1:0] == 2'b00);
        if (!sel) return;
        if (ram_mode) begin way = a[13]; idx = {a[14], a[12:5]}; end
        else          begin way = a[14]; idx = a[13:5]; end
        t = d[28:10];
        if (!w) begin
            e.is_hit = 1'b0; e.way = 1'b0; e.rq = rq;
            e.data = {3'b000, m_tag[way][idx], 8'h00, m_u[way][idx], m_v[way][idx]};
            e.mask = m_known[way][idx] ? 32'hFFFF_FFFF : 32'h0000_0003;
            exp_q.push_back(e);
        end else if (!a[3]) begin
            m_tag[way][idx] = t; m_u[way][idx] = d[1]; m_v[way][idx] = d[0];
            m_known[way][idx] = 1'b1;
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (m_v[k][idx] && m_known[k][idx] && m_tag[k][idx] == t) begin
                    m_u[k][idx] = d[1]; m_v[k][idx] = d[0];
                    e.is_hit = 1'b1; e.way = k[0]; e.data = '0; e.mask = '0; e.rq = rq;
                    exp_q.push_back(e);
                    break;
                end
            end
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        end
    endtask

    // Monitor: pops expected items as outputs appear.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!rvalid && rdata != 32'h0)
                chk(1'b0, "R10", "rdata while idle", rdata, 32'h0);
            if (rvalid || hit_pulse) begin
                if (rvalid && hit_pulse) begin
                    chk(1'b0, "R8", "rvalid and hit together", {30'd0, rvalid, hit_pulse}, 32'h1);
                end else if (exp_q.size() == 0) begin
                    chk(1'b0, rvalid ? "R1" : "R8", "unexpected response", {30'd0, rvalid, hit_pulse}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.is_hit)
                        chk(hit_pulse && hit_way == e.way, e.rq, "hit way",
                            {30'd0, hit_pulse, hit_way}, {30'd0, 1'b1, e.way});
                    else
                        chk(rvalid && ((rdata & e.mask) == (e.data & e.mask)), e.rq, "read data",
                            rdata & e.mask, e.data & e.mask);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 512; i++) begin
                m_tag[w][i] = '0; m_v[w][i] = 0; m_u[w][i] = 0; m_known[w][i] = 0;
            end

        repeat (3) @(negedge clk);
        chk(!rvalid && !hit_pulse && rdata == 0, "R9", "outputs in reset",
            {rdata[31:2], rvalid, hit_pulse}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R9: flags clear after reset
        issue(0, mk_addr(0, 0, 0, 8'd0), 0, "R9");
        issue(0, mk_addr(0, 1, 1, 8'hFF), 0, "R9");
        issue(0, mk_addr(0, 1, 0, 8'h40), 0, "R9");
        idle(3);

        // R4/R6: direct write with reserved bits all set, read back
        issue(1, mk_addr(0, 0, 0, 8'd7), 32'hFFFF_FFFF, "R6");
        issue(0, mk_addr(0, 0, 0, 8'd7), 0, "R4");
        issue(1, mk_addr(0, 1, 1, 8'hFF), 32'h1234_5FFE, "R6");
        issue(0, mk_addr(0, 1, 1, 8'hFF), 0, "R2");
        issue(0, mk_addr(0, 0, 1, 8'hFF), 0, "R2");
        // R5: match flag set on a read changes nothing
        issue(0, mk_addr(1, 0, 0, 8'd7), 0, "R5");
        idle(3);

        // R7/R8: prepare entry 5 in both ways
        issue(1, mk_addr(0, 0, 0, 8'd5), {3'b000, 19'h0AAAA, 8'h00, 2'b01}, "R6");
        issue(1, mk_addr(0, 1, 0, 8'd5), {3'b000, 19'h05555, 8'h00, 2'b01}, "R6");
        issue(1, mk_addr(1, 0, 0, 8'd5), {3'b000, 19'h05555, 8'h00, 2'b11}, "R8");
        idle(2);
        issue(0, mk_addr(0, 1, 0, 8'd5), 0, "R7");
        issue(0, mk_addr(0, 0, 0, 8'd5), 0, "R7");
        // miss: nothing written, no pulse
        issue(1, mk_addr(1, 0, 0, 8'd5), {3'b111, 19'h01234, 8'hFF, 2'b11}, "R7");
        idle(2);
        issue(0, mk_addr(0, 0, 0, 8'd5), 0, "R7");
        issue(0, mk_addr(0, 1, 0, 8'd5), 0, "R7");
        idle(2);

        // invalid way with matching tag does not hit
        issue(1, mk_addr(0, 0, 0, 8'd9), {3'b000, 19'h00777, 8'h00, 2'b10}, "R6");
        issue(1, mk_addr(1, 0, 0, 8'd9), {3'b000, 19'h00777, 8'h00, 2'b01}, "R7");
        idle(2);
        issue(0, mk_addr(0, 0, 0, 8'd9), 0, "R7");
        // both ways match: way 0 chosen; clear V through the match path
        issue(1, mk_addr(0, 0, 0, 8'd11), {3'b000, 19'h3C3C3, 8'h00, 2'b01}, "R6");
        issue(1, mk_addr(0, 1, 0, 8'd11), {3'b000, 19'h3C3C3, 8'h00, 2'b01}, "R6");
        issue(1, mk_addr(1, 0, 0, 8'd11), {3'b000, 19'h3C3C3, 8'h00, 2'b00}, "R8");
        issue(0, mk_addr(0, 0, 0, 8'd11), 0, "R7");
        issue(0, mk_addr(0, 1, 0, 8'd11), 0, "R7");
        idle(3);

        // R1: ignored addresses
        issue(1, {8'hF5, mk_addr(0, 0, 0, 8'd7) & 32'h00FF_FFFF}, 32'h0, "R1");
        issue(1, mk_addr(0, 0, 0, 8'd7) | 32'h2, 32'h0, "R1");
        issue(0, {8'hE4, mk_addr(0, 0, 0, 8'd7) & 32'h00FF_FFFF}, 32'h0, "R1");
        idle(1);
        chk(!rvalid, "R1", "no response to foreign read", {31'd0, rvalid}, 32'h0);
        issue(0, mk_addr(0, 0, 0, 8'd7), 0, "R1");
        idle(3);

        // R3: RAM mode moves the way bit to 13
        ram_mode = 1'b1;
        issue(1, mk_addr(0, 0, 1, 8'd3), {3'b000, 19'h11111, 8'h00, 2'b11}, "R3");
        issue(1, mk_addr(0, 1, 0, 8'd3), {3'b000, 19'h22222, 8'h00, 2'b01}, "R3");
        issue(0, mk_addr(0, 0, 1, 8'd3), 0, "R3");
        idle(2);
        ram_mode = 1'b0;
        issue(0, mk_addr(0, 1, 0, 8'd3), 0, "R3");
        issue(0, mk_addr(0, 0, 1, 8'd3), 0, "R3");
        idle(3);

        // R11: match write followed at once by a direct write to the same location
        issue(1, mk_addr(0, 1, 0, 8'd20), {3'b000, 19'h0BEEF, 8'h00, 2'b01}, "R11");
        idle(1);
        issue(1, mk_addr(1, 1, 0, 8'd20), {3'b000, 19'h0BEEF, 8'h00, 2'b11}, "R11");
        issue(1, mk_addr(0, 1, 0, 8'd20), {3'b000, 19'h0CAFE, 8'h00, 2'b00}, "R11");
        issue(0, mk_addr(0, 1, 0, 8'd20), 0, "R11");
        // write then read back to back
        issue(1, mk_addr(0, 0, 1, 8'd20), {3'b000, 19'h7FFFF, 8'h00, 2'b11}, "R11");
        issue(0, mk_addr(0, 0, 1, 8'd20), 0, "R11");
        idle(5);

        chk(exp_q.size() == 0, "R8", "pending expected responses", exp_q.size(), 32'h0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule